// File: doc/BRIEF.md
# Gated-Clock Parallel-In Serial-Out Shift Register

This block is a chain of stages that converts a parallel word into a serial bit stream. A word is captured into all stages at once by holding the active-low load control low. While that control is low it overrides every clock and serial input. When the load control is high, the chain shifts one place toward the output on each qualified shift edge. On each shift a new bit enters the first stage from the serial input. The last stage drives a true serial output and its inverse.

The shift strobe and the inhibit input are two inputs of the same OR gate. Both are sampled in the system clock domain. A rising edge of their OR is one shift request, so either input can act as the strobe while the other acts as a gate. The inhibit should rise only while the strobe is high; otherwise the rise is itself taken as an edge. Stage 0 is the entry stage and stage `WIDTH-1` feeds the outputs. Parallel bit `k` loads stage `k`.

Top module: `piso_shift_reg`

## Requirements
- R1: At every rising clock edge where `load_ni` is low, all stages take `par_i`, whatever `sclk_i`, `sclk_inh_i` and `ser_i` are. `q_o` then equals `par_i[WIDTH-1]`.
- R2: A shift request that occurs in a cycle with `load_ni` low is discarded in favour of the load. After `load_ni` returns high, the loaded word is held until the next fresh shift request.
- R3: A shift request is a rising edge of (`sclk_i` OR `sclk_inh_i`): the OR is high at this clock edge and was low at the previous one. Each request with `load_ni` high moves the chain exactly one stage.
- R4: On a shift, stage 0 takes `ser_i` and stage k takes stage k-1. After a load, successive shifts present `par_i[WIDTH-2]` down to `par_i[0]` on `q_o`, then the serial bits in the order they were shifted in.
- R5: While `sclk_inh_i` stays high, the stages hold their value however `sclk_i` toggles.
- R6: With `load_ni` high and no shift request, the stages hold their value, both with the strobe held high and with it held low.
- R7: `q_no` is always the inverse of `q_o`.
- R8: An asynchronous low on `rst_ni` clears every stage, giving `q_o` = 0 and `q_no` = 1.
- R9: With `sclk_i` low, a rise of `sclk_inh_i` counts as a shift request, so the two inputs are interchangeable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Low: parallel load; high: shift mode |
| sclk_i | input | 1 | Shift strobe, sampled |
| sclk_inh_i | input | 1 | Shift inhibit, ORed with the strobe |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data, bit k to stage k |
| q_o | output | 1 | Last stage |
| q_no | output | 1 | Inverse of last stage |

## Verification
The bench holds the strobe high across a load and across load release. A design that ignores load priority would shift one place too early and show `par_i[WIDTH-2]` in place of the top bit. It drops the inhibit while the strobe is high, which must not shift, and raises it while the strobe is low, which must shift. A design that used a plain enable in place of the OR would get both of these wrong. It shifts a whole word through and on into serial data, which exposes a reversed shift direction or a wrong entry bit. It also holds the strobe high for several cycles, where a level-triggered design would shift on every cycle.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } piso_op_e;
endpackage

// File: rtl/piso_clk_qual.sv
module piso_clk_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sclk_inh_i,
  output logic edge_o
);
  logic gate_d, gate_q;

  assign gate_d = sclk_i | sclk_inh_i;

  // reset high: a strobe held high through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_d;
  end

  assign edge_o = gate_d & ~gate_q;
endmodule

// File: rtl/piso_op_sel.sv
module piso_op_sel
  import piso_pkg::*;
(
  input  logic     load_ni,
  input  logic     edge_i,
  output piso_op_e op_o
);
  always_comb begin
    if (!load_ni)    op_o = OP_LOAD;
    else if (edge_i) op_o = OP_SHIFT;
    else             op_o = OP_HOLD;
  end
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  piso_op_e         op_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] stage_o
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] prev;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign prev[k] = ser_i;
    end else begin : g_body
      assign prev[k] = stage_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[k] <= 1'b0;
      end else begin
        unique case (op_i)
          OP_LOAD:  stage_q[k] <= par_i[k];
          OP_SHIFT: stage_q[k] <= prev[k];
          default:  stage_q[k] <= stage_q[k];
        endcase
      end
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             sclk_i,
  input  logic             sclk_inh_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             q_o,
  output logic             q_no
);
  localparam int LAST = WIDTH - 1;

  logic             shift_edge;
  piso_op_e         op;
  logic [WIDTH-1:0] stage_q;

  piso_clk_qual i_clk_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .sclk_inh_i (sclk_inh_i),
    .edge_o     (shift_edge)
  );

  piso_op_sel i_op_sel (
    .load_ni (load_ni),
    .edge_i  (shift_edge),
    .op_o    (op)
  );

  piso_stage_chain #(.WIDTH(WIDTH)) i_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .stage_o (stage_q)
  );

  assign q_o  = stage_q[LAST];
  assign q_no = ~stage_q[LAST];
endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic             sclk_i,
  input logic             sclk_inh_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] stage_i,
  input logic             q_o,
  input logic             q_no
);
  logic gate_prev;
  logic req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_prev <= 1'b1;
    else         gate_prev <= sclk_i | sclk_inh_i;
  end

  assign req = (sclk_i | sclk_inh_i) & ~gate_prev;

  // R7
  comp_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_no == ~q_o);

  // R1
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> stage_i == $past(par_i));

  // R2
  load_beats_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && req) |=> q_o == $past(par_i[WIDTH-1]));

  // R4
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && req) |=> stage_i == {$past(stage_i[WIDTH-2:0]), $past(ser_i)});

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !req) |=> $stable(stage_i));

  // R5
  inh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && sclk_inh_i && gate_prev) |=> $stable(stage_i));
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .sclk_i     (sclk_i),
  .sclk_inh_i (sclk_inh_i),
  .ser_i      (ser_i),
  .par_i      (par_i),
  .stage_i    (stage_q),
  .q_o        (q_o),
  .q_no       (q_no)
);

// File: tb/test_piso_shift_reg.sv
module test_piso_shift_reg;
  localparam int WIDTH = 8;
  localparam int NVEC  = 30;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b1;
  logic             load_ni = 1'b1;
  logic             sclk_i = 1'b0;
  logic             sclk_inh_i = 1'b0;
  logic             ser_i = 1'b0;
  logic [WIDTH-1:0] par_i = '0;
  logic             q_o, q_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  piso_shift_reg #(.WIDTH(WIDTH)) i_piso_shift_reg (
    .clk_i, .rst_ni, .load_ni, .sclk_i, .sclk_inh_i, .ser_i, .par_i, .q_o, .q_no
  );

  // {load_n, sclk, inh, ser, par[7:0], expected q}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_0_0_0_10100110_1,  // 0  load A6
    13'b1_0_0_1_10100110_1,
    13'b1_1_0_0_10100110_0,  // 2  shift -> par[6]
    13'b1_1_0_1_00000000_0,  //    strobe held high
    13'b1_0_0_1_11111111_0,
    13'b1_1_0_1_00000000_1,  // 5  -> par[5]
    13'b1_0_0_0_00000000_1,
    13'b1_0_1_0_00000000_0,  // 7  inhibit rise with strobe low -> par[4]
    13'b1_1_1_1_11111111_0,
    13'b1_0_1_0_11111111_0,
    13'b1_1_1_1_00000000_0,
    13'b1_1_0_0_00000000_0,  // 11 inhibit falls under high strobe
    13'b1_0_0_1_00000000_0,
    13'b1_1_0_1_00000000_0,  // 13 -> par[3]
    13'b1_0_0_0_00000000_0,
    13'b1_1_0_0_00000000_1,  // 15 -> par[2]
    13'b1_0_0_1_00000000_1,
    13'b1_1_0_1_00000000_1,  // 17 -> par[1]
    13'b1_0_0_0_00000000_1,
    13'b1_1_0_0_00000000_0,  // 19 -> par[0]
    13'b0_0_0_1_11000011_1,  // 20 load C3
    13'b0_1_0_0_11000011_1,  // 21 strobe rises during load
    13'b1_1_0_1_00000000_1,  // 22 release, no fresh edge
    13'b1_0_0_0_00000000_1,
    13'b1_1_0_0_00000000_1,  // 24 -> par[6]
    13'b1_0_0_1_00000000_1,
    13'b1_1_0_1_00000000_0,  // 26 -> par[5]
    13'b0_1_1_0_00000000_0,  // 27 load under inhibit
    13'b0_0_0_1_10000000_1,  // 28 load follows par
    13'b1_0_0_0_10000000_1
  };

  task automatic check(input string tag, input logic exp);
    checks++;
    if (q_o !== exp) begin
      errors++;
      $display("FAIL %s q_o actual %b expected %b", tag, q_o, exp);
    end
    checks++;
    if (q_no !== ~exp) begin
      errors++;
      $display("FAIL R7 (%s) q_no actual %b expected %b", tag, q_no, ~exp);
    end
  endtask

  task automatic step(input logic ld, input logic ck, input logic ih,
                      input logic sr, input logic [WIDTH-1:0] pv);
    load_ni = ld; sclk_i = ck; sclk_inh_i = ih; ser_i = sr; par_i = pv;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R8", 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:1]);
      if (i == 7)               tag = "R9";
      else if (i == 21 || i == 22) tag = "R2";
      else if (!VEC[i][12])     tag = "R1";
      else if (VEC[i][10])      tag = "R5";
      else                      tag = "R3";
      check(tag, VEC[i][0]);
    end

    // R6: no request with strobe held low, then held high
    for (int i = 0; i < 3; i++) begin step(1, 0, 0, 0, '0); check("R6", 1'b1); end
    step(1, 1, 0, 0, '0); check("R3", 1'b0);
    for (int i = 0; i < 3; i++) begin step(1, 1, 0, 1, '1); check("R6", 1'b0); end

    // R4: full word out, then serial bits in shift order
    begin
      logic [WIDTH-1:0] word = 8'b1011_0010;
      logic [WIDTH-1:0] sbits = 8'b0100_1101;  // bit j shifted in at shift j
      step(1, 0, 0, 0, '0);
      step(0, 0, 0, 0, word);
      check("R4", word[WIDTH-1]);
      for (int j = 0; j < 2*WIDTH - 1; j++) begin
        logic e;
        step(1, 1, 0, sbits[j % WIDTH], '0);
        e = (j < WIDTH - 1) ? word[WIDTH-2-j] : sbits[j-(WIDTH-1)];
        check("R4", e);
        step(1, 0, 0, 0, '0);
      end
    end

    // R5: inhibit raised while strobe high, strobe toggles freely
    step(0, 1, 0, 0, 8'h55);
    step(0, 1, 1, 0, 8'h55);
    check("R1", 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1, i[0], 1, 1, '0);
      check("R5", 1'b0);
    end
    step(1, 1, 1, 0, '0);
    step(1, 1, 0, 0, '0); check("R5", 1'b0);
    step(1, 0, 0, 0, '0);
    step(1, 1, 0, 0, '0); check("R3", 1'b1);

    // R8: reset mid-stream
    step(0, 0, 0, 0, 8'hFF);
    check("R1", 1'b1);
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8", 1'b0);
    rst_ni = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule